// File: doc/BRIEF.md
# Accumulator ALU with Packed Flag Register

This block is the arithmetic and flag datapath of a small accumulator CPU. Each cycle it takes an operation code, the accumulator byte and a second operand byte. It then computes a result byte and the condition-flag byte that the operation would leave behind. Both come out combinationally. The block holds the flag byte in a register and updates it on a write strobe.

The flag byte keeps four condition bits in its upper nibble: Zero in bit 7, Subtract in bit 6, Half-carry in bit 5 and Carry in bit 4. Its lower nibble is always zero. The stored flags are the "current" flags for every operation:

- ADC and SBC read the stored Carry.
- INC, DEC, CPL and BIT pass some stored bits through.
- Decimal adjust reads stored Subtract, Half-carry and Carry.

The surrounding core writes a whole flag byte through a separate load port, for example when it restores flags from the stack.

Instruction decode picks the operation and the operand. The register file stores the result. For the stack-pointer displacement operation, the accumulator port carries the low byte of the pointer and the operand port carries the displacement. The block produces that low-byte sum and its flags, and the core forms the high byte.

Top module: `alu8_flag_unit`

## Requirements
- R1: Out of reset the stored flag byte equals the parameter RST_F (default 0x00), and its bits 3..0 always read 0. Zero is bit 7, Subtract bit 6, Half-carry bit 5, Carry bit 4.
- R2: Code 0 (add) and code 1 (add with stored Carry) give result A+B(+C) mod 256. Zero is set when the result is 0 and Subtract is cleared. Half-carry is the carry out of bit 3 and Carry is the carry out of bit 7.
- R3: Code 2 (subtract), code 3 (subtract with stored Carry) and code 4 (compare) set Subtract. Half-carry is the borrow out of bit 3 and Carry is the borrow out of bit 7. Zero is set from the difference. Code 4 returns A unchanged as the result.
- R4: Code 8 (A+1) and code 9 (A−1) set Zero from the result. Half-carry is the low-nibble carry or borrow. Subtract is set only for code 9. Carry is left unchanged.
- R5: Code 5 (AND) sets Half-carry and clears Subtract and Carry. Code 6 (XOR) and code 7 (OR) clear Subtract, Half-carry and Carry. All three set Zero from the result.
- R6: Code 10 returns ~A, sets Subtract and Half-carry, and leaves Zero and Carry unchanged.
- R7: Code 11 tests bit bit_sel of the operand. It sets Zero when that bit is 0, clears Subtract, sets Half-carry, keeps Carry and returns A.
- R8: Code 12 (decimal adjust) builds a correction value, with 0x60 added when Carry is set or when (Subtract is clear and A > 0x99). 0x06 is added when Half-carry is set or when (Subtract is clear and A[3:0] > 9). The correction is added to A when Subtract is clear and subtracted when it is set. New Carry is set exactly when 0x60 is in the correction. Half-carry is cleared, Subtract is kept, and Zero is set from the result.
- R9: Code 13 (pointer displacement) returns (A+B) mod 256 and clears Zero and Subtract. Half-carry is the carry out of bit 3 and Carry is the carry out of bit 7.
- R10: The flag register takes f_next on a rising edge with wr_en high and holds otherwise. f_ld loads f_in with bits 3..0 cleared and wins over wr_en.
- R11: Codes 14 and 15 return A and give f_next equal to the stored flag byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sel | input | 4 | Operation code |
| acc_in | input | DW | Accumulator (or pointer low byte) |
| opd_in | input | DW | Second operand (or displacement) |
| bit_sel | input | log2(DW) | Bit index for the bit test |
| f_in | input | DW | Flag byte to load |
| f_ld | input | 1 | Load f_in into the flag register |
| wr_en | input | 1 | Commit f_next into the flag register |
| res_out | output | DW | Result byte |
| f_next | output | DW | Flag byte produced by the operation |
| f_q | output | DW | Stored flag byte |

## Verification
The bench builds the block with DW = 8 and RST_F = 0x00, so the whole operand space is only 65,536 pairs per operation. That size lets the bench sweep every two-operand operation over all operand pairs, once with the stored flag byte at 0x00 and once at 0xF0. It also sweeps every single-operand operation, decimal adjust and the bit test against all sixteen stored flag nibbles. A zero reset value makes the first commit and load visibly change the register.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_XOR = 4'd6,
        OP_OR  = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_CPL = 4'd10,
        OP_TST = 4'd11,
        OP_DAJ = 4'd12,
        OP_SPD = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    localparam int FLAG_BITS = 4;
    localparam int NIB_W     = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    input  logic          unit_step,
    output logic [DW-1:0] sum,
    output logic          half_out,
    output logic          carry_out
);
    import alu8_pkg::*;

    logic [DW-1:0]  b_eff;
    logic           c_eff;
    logic [DW:0]    wide;
    logic [NIB_W:0] low;

    always_comb begin
        b_eff = unit_step ? DW'(1) : b;
        c_eff = unit_step ? 1'b0 : cin;
        if (sub) begin
            wide = {1'b0, a} - {1'b0, b_eff} - {{DW{1'b0}}, c_eff};
            low  = {1'b0, a[NIB_W-1:0]} - {1'b0, b_eff[NIB_W-1:0]}
                 - {{NIB_W{1'b0}}, c_eff};
        end else begin
            wide = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
            low  = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
                 + {{NIB_W{1'b0}}, c_eff};
        end
        sum       = wide[DW-1:0];
        half_out  = low[NIB_W];
        carry_out = wide[DW];
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int DW = 8,
    parameter int BW = $clog2(DW)
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [BW-1:0] bsel,
    output logic [DW-1:0] and_r,
    output logic [DW-1:0] xor_r,
    output logic [DW-1:0] or_r,
    output logic [DW-1:0] inv_r,
    output logic          tested_clear
);

    always_comb begin
        and_r        = a & b;
        xor_r        = a ^ b;
        or_r         = a | b;
        inv_r        = ~a;
        tested_clear = ~b[bsel];
    end

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic          n_in,
    input  logic          h_in,
    input  logic          c_in,
    output logic [DW-1:0] adj,
    output logic          c_out
);
    import alu8_pkg::*;

    localparam logic [DW-1:0] HI_LIMIT = DW'(8'h99);
    localparam logic [NIB_W-1:0] LO_LIMIT = NIB_W'(9);

    logic          hi_fix;
    logic          lo_fix;
    logic [DW-1:0] corr;

    always_comb begin
        hi_fix = c_in | (~n_in & (a > HI_LIMIT));
        lo_fix = h_in | (~n_in & (a[NIB_W-1:0] > LO_LIMIT));
        corr   = '0;
        corr[1] = lo_fix;
        corr[2] = lo_fix;
        corr[5] = hi_fix;
        corr[6] = hi_fix;
        adj    = n_in ? (a - corr) : (a + corr);
        c_out  = hi_fix;
    end

endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit #(
    parameter int DW = 8,
    parameter logic [DW-1:0] RST_F = '0,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opd_in,
    input  logic [BW-1:0] bit_sel,
    input  logic [DW-1:0] f_in,
    input  logic          f_ld,
    input  logic          wr_en,
    output logic [DW-1:0] res_out,
    output logic [DW-1:0] f_next,
    output logic [DW-1:0] f_q
);
    import alu8_pkg::*;

    localparam int PAD_W = DW - FLAG_BITS;
    localparam logic [DW-1:0] F_MASK = {{FLAG_BITS{1'b1}}, {PAD_W{1'b0}}};

    alu_op_e       op;
    flags_t        cur;
    flags_t        nf;
    logic [DW-1:0] f_reg;

    logic          as_sub, as_step, as_cin;
    logic [DW-1:0] as_sum;
    logic          as_h, as_c;

    logic [DW-1:0] lg_and, lg_xor, lg_or, lg_inv;
    logic          lg_tclr;

    logic [DW-1:0] dj_res;
    logic          dj_c;

    assign op  = alu_op_e'(op_sel);
    assign cur = flags_t'(f_reg[DW-1 -: FLAG_BITS]);

    always_comb begin
        as_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
        as_step = (op == OP_INC) || (op == OP_DEC);
        as_cin  = ((op == OP_ADC) || (op == OP_SBC)) && cur.c;
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a         (acc_in),
        .b         (opd_in),
        .cin       (as_cin),
        .sub       (as_sub),
        .unit_step (as_step),
        .sum       (as_sum),
        .half_out  (as_h),
        .carry_out (as_c)
    );

    alu8_logic #(.DW(DW), .BW(BW)) u_logic (
        .a            (acc_in),
        .b            (opd_in),
        .bsel         (bit_sel),
        .and_r        (lg_and),
        .xor_r        (lg_xor),
        .or_r         (lg_or),
        .inv_r        (lg_inv),
        .tested_clear (lg_tclr)
    );

    alu8_daa #(.DW(DW)) u_daa (
        .a     (acc_in),
        .n_in  (cur.n),
        .h_in  (cur.h),
        .c_in  (cur.c),
        .adj   (dj_res),
        .c_out (dj_c)
    );

    always_comb begin
        res_out = acc_in;
        nf      = cur;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res_out = as_sum;
                nf = '{z: (as_sum == '0), n: 1'b0, h: as_h, c: as_c};
            end
            OP_SUB, OP_SBC: begin
                res_out = as_sum;
                nf = '{z: (as_sum == '0), n: 1'b1, h: as_h, c: as_c};
            end
            OP_CMP: begin
                res_out = acc_in;
                nf = '{z: (as_sum == '0), n: 1'b1, h: as_h, c: as_c};
            end
            OP_INC: begin
                res_out = as_sum;
                nf = '{z: (as_sum == '0), n: 1'b0, h: as_h, c: cur.c};
            end
            OP_DEC: begin
                res_out = as_sum;
                nf = '{z: (as_sum == '0), n: 1'b1, h: as_h, c: cur.c};
            end
            OP_AND: begin
                res_out = lg_and;
                nf = '{z: (lg_and == '0), n: 1'b0, h: 1'b1, c: 1'b0};
            end
            OP_XOR: begin
                res_out = lg_xor;
                nf = '{z: (lg_xor == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_OR: begin
                res_out = lg_or;
                nf = '{z: (lg_or == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_CPL: begin
                res_out = lg_inv;
                nf = '{z: cur.z, n: 1'b1, h: 1'b1, c: cur.c};
            end
            OP_TST: begin
                res_out = acc_in;
                nf = '{z: lg_tclr, n: 1'b0, h: 1'b1, c: cur.c};
            end
            OP_DAJ: begin
                res_out = dj_res;
                nf = '{z: (dj_res == '0), n: cur.n, h: 1'b0, c: dj_c};
            end
            OP_SPD: begin
                res_out = as_sum;
                nf = '{z: 1'b0, n: 1'b0, h: as_h, c: as_c};
            end
            default: begin
                res_out = acc_in;
                nf      = cur;
            end
        endcase
        f_next = {nf, {PAD_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_reg <= RST_F & F_MASK;
        end else if (f_ld) begin
            f_reg <= f_in & F_MASK;
        end else if (wr_en) begin
            f_reg <= f_next;
        end
    end

    assign f_q = f_reg;

endmodule

// File: rtl/alu8_flag_unit_chk.sv
module alu8_flag_unit_chk #(
    parameter int DW = 8,
    parameter int BW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_sel,
    input logic [DW-1:0] acc_in,
    input logic [DW-1:0] f_in,
    input logic          f_ld,
    input logic          wr_en,
    input logic [DW-1:0] res_out,
    input logic [DW-1:0] f_next,
    input logic [DW-1:0] f_q
);
    import alu8_pkg::*;

    a_r1_low_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        f_q[NIB_W-1:0] == '0);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !f_ld) |=> $stable(f_q));

    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !f_ld) |=> (f_q == $past(f_next)));

    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        f_ld |=> (f_q[DW-1 -: FLAG_BITS] == $past(f_in[DW-1 -: FLAG_BITS])));

    a_r4_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel == 4'(OP_INC)) || (op_sel == 4'(OP_DEC))) |-> (f_next[4] == f_q[4]));

    a_r6_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'(OP_CPL)) |-> ((res_out == ~acc_in) && (f_next[6:5] == 2'b11)));

    a_r9_zn_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'(OP_SPD)) |-> (f_next[7:6] == 2'b00));

    a_r3_cmp_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'(OP_CMP)) |-> (res_out == acc_in));

    a_r11_idle_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd14) |-> ((f_next == f_q) && (res_out == acc_in)));

endmodule

bind alu8_flag_unit alu8_flag_unit_chk #(.DW(DW), .BW(BW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .acc_in  (acc_in),
    .f_in    (f_in),
    .f_ld    (f_ld),
    .wr_en   (wr_en),
    .res_out (res_out),
    .f_next  (f_next),
    .f_q     (f_q)
);

// File: tb/alu8_flag_unit_tb.sv
`timescale 1ns/1ps
module alu8_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0, opd_in = '0, f_in = '0;
    logic [2:0] bit_sel = '0;
    logic       f_ld = 1'b0, wr_en = 1'b0;
    logic [7:0] res_out, f_next, f_q;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_f = 8'h00;

    always #10 clk = ~clk;

    alu8_flag_unit #(.DW(8), .RST_F(8'h00)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in),
        .opd_in(opd_in), .bit_sel(bit_sel), .f_in(f_in), .f_ld(f_ld),
        .wr_en(wr_en), .res_out(res_out), .f_next(f_next), .f_q(f_q)
    );

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            if (n_bad < 30)
                $display("FAIL %s %s: actual %02h expected %02h (op %0d a %02h b %02h)",
                         req, what, act, exp, op_sel, acc_in, opd_in);
        end
    endtask

    // Reference built from the requirement text; returns {result, flag byte}.
    function automatic logic [15:0] model(input int op, input int a, input int b,
                                          input int bs, input logic [7:0] f);
        int r, t, corr;
        bit z, n, h, c;
        z = f[7]; n = f[6]; h = f[5]; c = f[4];
        r = a;
        case (op)
            0, 1: begin
                t = (op == 1) ? int'(c) : 0;
                h = ((a % 16) + (b % 16) + t) > 15;
                r = a + b + t; c = r > 255; r = r % 256; n = 0; z = (r == 0);
            end
            2, 3, 4: begin
                t = (op == 3) ? int'(c) : 0;
                h = ((a % 16) - (b % 16) - t) < 0;
                r = a - b - t; c = r < 0; r = (r + 512) % 256; n = 1; z = (r == 0);
                if (op == 4) r = a;
            end
            5: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; end
            6: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; end
            7: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; end
            8: begin h = (a % 16) == 15; r = (a + 1) % 256; z = (r == 0); n = 0; end
            9: begin h = (a % 16) == 0; r = (a + 255) % 256; z = (r == 0); n = 1; end
            10: begin r = 255 - a; n = 1; h = 1; end
            11: begin r = a; z = ((b >> bs) % 2) == 0; n = 0; h = 1; end
            12: begin
                corr = 0;
                if (c || (!n && a > 153)) corr += 96;
                if (h || (!n && (a % 16) > 9)) corr += 6;
                r = n ? (a - corr + 256) % 256 : (a + corr) % 256;
                c = corr >= 96; h = 0; z = (r == 0);
            end
            13: begin
                h = ((a % 16) + (b % 16)) > 15;
                r = a + b; c = r > 255; r = r % 256; z = 0; n = 0;
            end
            default: r = a;
        endcase
        return {8'(r), z, n, h, c, 4'b0000};
    endfunction

    task automatic apply_check(input string req, input int op, input int a,
                               input int b, input int bs);
        logic [15:0] m;
        op_sel = 4'(op); acc_in = 8'(a); opd_in = 8'(b); bit_sel = 3'(bs);
        #1;
        m = model(op, a, b, bs, exp_f);
        check8(req, "result", res_out, m[15:8]);
        check8(req, "f_next", f_next, m[7:0]);
    endtask

    task automatic load_flags(input logic [7:0] v);
        @(negedge clk);
        f_in = v; f_ld = 1'b1;
        @(posedge clk); #1;
        f_ld = 1'b0;
        exp_f = v & 8'hF0;
    endtask

    task automatic t_reset;
        #1;
        check8("R1", "f_q in reset", f_q, 8'h00);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check8("R1", "f_q after reset", f_q, 8'h00);
    endtask

    task automatic t_sweep2(input string req, input int op);
        for (int fv = 0; fv < 2; fv++) begin
            load_flags(fv == 0 ? 8'h00 : 8'hF0);
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    apply_check(req, op, a, b, 0);
        end
    endtask

    task automatic t_sweep1(input string req, input int op);
        for (int fv = 0; fv < 16; fv++) begin
            load_flags(8'(fv << 4));
            for (int a = 0; a < 256; a++)
                apply_check(req, op, a, 8'h3C, 0);
        end
    endtask

    task automatic t_bittest;
        for (int fv = 0; fv < 16; fv++) begin
            load_flags(8'(fv << 4));
            for (int b = 0; b < 256; b++)
                for (int bs = 0; bs < 8; bs++)
                    apply_check("R7", 11, 8'hA5, b, bs);
        end
    endtask

    task automatic t_corners;
        load_flags(8'h00);
        apply_check("R3", 2, 8'h3E, 8'h3E, 0);   // A-A: Z,N only -> C0
        check8("R3", "self-subtract flags", f_next, 8'hC0);
        apply_check("R8", 12, 8'h9A, 0, 0);      // 9A +66 -> 00, Z,C
        check8("R8", "daa wrap", f_next, 8'h90);
        apply_check("R2", 0, 8'hFF, 8'h01, 0);
        check8("R2", "add wrap flags", f_next, 8'hB0);
    endtask

    task automatic t_idle_codes;
        load_flags(8'hA0);
        for (int op = 14; op < 16; op++)
            for (int a = 0; a < 256; a += 17)
                apply_check("R11", op, a, 255 - a, 0);
        check8("R11", "f_next equals stored", f_next, 8'hA0);
    endtask

    task automatic t_register;
        load_flags(8'h00);
        @(negedge clk);
        op_sel = 4'd0; acc_in = 8'hFF; opd_in = 8'h01; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        check8("R10", "commit on wr_en", f_q, 8'hB0);
        @(negedge clk);
        op_sel = 4'd6; acc_in = 8'h12; opd_in = 8'h34;
        @(posedge clk); #1;
        check8("R10", "hold without wr_en", f_q, 8'hB0);
        @(negedge clk);
        f_in = 8'h5A; f_ld = 1'b1; wr_en = 1'b1;
        @(posedge clk); #1;
        f_ld = 1'b0; wr_en = 1'b0;
        check8("R10", "load wins, low nibble cleared", f_q, 8'h50);
        check8("R1", "low nibble zero", f_q & 8'h0F, 8'h00);
        exp_f = 8'h50;
    endtask

    initial begin
        t_reset();
        t_register();
        t_corners();
        t_sweep2("R2", 0);
        t_sweep2("R2", 1);
        t_sweep2("R3", 2);
        t_sweep2("R3", 3);
        t_sweep2("R3", 4);
        t_sweep2("R5", 5);
        t_sweep2("R5", 6);
        t_sweep2("R5", 7);
        t_sweep2("R9", 13);
        t_sweep1("R4", 8);
        t_sweep1("R4", 9);
        t_sweep1("R6", 10);
        t_sweep1("R8", 12);
        t_bittest();
        t_idle_codes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule